// File: doc/BRIEF.md
# Frame-by-Frame Stream CRC Checker

This block checks a word stream that is loaded as a run of fixed-length frames. Every frame is `frame_len` data words long and is followed by one 32-bit check word. The block computes a CRC-32 over the data words of each frame and compares it with the check word that follows. A run begins with a `start` pulse, which also captures the number of frames and the frame length. The run ends at the first frame whose check word does not match, or once the last frame has passed, whichever comes first.

A run in which every frame passes produces a one-cycle `done` pulse. At the same time it stores a 32-bit signature of the whole load in a holding register. The signature is a CRC over every data word of every frame, excluding the check words, and is kept for a later background check. A failing run raises `error`, reports the zero-based index of the failing frame, and stops accepting words until the next `start`.

The controller has four states:
- `ST_IDLE`: waiting for a run.
- `ST_DATA`: taking the data words of a frame.
- `ST_CRC`: taking the check word of a frame.
- `ST_FAIL`: a mismatch has stopped the run.

It has these transitions:
- `T_START` moves from idle or fail to data.
- `T_EMPTY` goes from idle or fail back to idle when the frame count is zero.
- `T_FRAME_END` moves from data to CRC after the last data word.
- `T_NEXT` moves from CRC to data when a frame passes and more frames remain.
- `T_PASS` moves from CRC to idle when the last frame passes.
- `T_MISMATCH` moves from CRC to fail.

Top module: `frame_crc_checker`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `error` and `in_ready` are 0, and `fail_idx` and `crc_store` are 0.
- R2: A `start` pulse in idle or fail with a nonzero `frame_count` latches `frame_count` and `frame_len`, clears `error` and `fail_idx`, and drives `busy` and `in_ready` to 1 from the next cycle.
- R3: The CRC is computed on 32-bit words using the reflected form of the polynomial 0x04C11DB7 (0xEDB88320), with word bit 0 processed first. It is preset to 0xFFFFFFFF and the result is complemented. For example, a single word 0x34333231 gives 0x9BE3E0A3. The accumulator restarts at the first data word of every frame.
- R4: Each frame is `frame_len` data words followed by one check word. A word is taken only on a cycle where `in_valid` and `in_ready` are both 1, so idle gaps in `in_valid` do not change the result.
- R5: When the check word of the last frame matches, `done` is 1 for exactly the one cycle after that word is taken. In that cycle `error` and `busy` are 0.
- R6: When a check word does not match, `error` goes to 1 and `fail_idx` shows the zero-based frame index from the next cycle. `busy` and `in_ready` are 0 and `done` stays 0. Further valid words are not taken until `start`.
- R7: On a passing run, `crc_store` takes the R3 CRC computed over all data words of all frames in stream order, in the same cycle `done` rises. On a failing run `crc_store` keeps its previous value.
- R8: A `start` pulse while `busy` is 1 is ignored: the run continues with the count and length it started with.
- R9: A `start` with `frame_count` of 0 gives a `done` pulse in the next cycle without taking any word, and stores 0x00000000 in `crc_store`.
- R10: A `frame_len` of 0 is treated as one data word per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a run when not busy |
| frame_count | input | CNT_W | Number of frames in the run |
| frame_len | input | LEN_W | Data words per frame (0 treated as 1) |
| in_valid | input | 1 | Stream word valid |
| in_data | input | 32 | Stream word |
| in_ready | output | 1 | Block takes a word this cycle if valid |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: all frames passed |
| error | output | 1 | A frame failed its check |
| fail_idx | output | CNT_W | Zero-based index of the failing frame |
| crc_store | output | 32 | Stored signature of the last passing load |

## Verification
The bench checks a known single-word CRC value. A design with the wrong bit order, preset or final inversion would fail that frame. It also sends multi-frame loads with gaps in `in_valid`. Here a checker that did not restart the accumulator per frame would flag frame 1, and one that counted idle cycles as words would lose framing. Corrupting the middle frame and the last frame checks that the failing index is exact, that no `done` appears, that the stored signature is untouched, and that later valid words are refused. A stray `start` in mid-run, a zero frame count and a zero frame length are the edges where a design would restart, hang or underflow its word counter.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;
    localparam int unsigned CRC_W     = 32;
    localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_INIT  = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_CRC  = 2'd2,
        ST_FAIL = 2'd3
    } fcc_state_e;
endpackage

// File: rtl/crc32_word_step.sv
module crc32_word_step
    import frame_crc_pkg::*;
(
    input  logic [CRC_W-1:0] seed,
    input  logic [CRC_W-1:0] word,
    output logic [CRC_W-1:0] nxt
);
    logic [CRC_W-1:0] chain [CRC_W+1];

    assign chain[0] = seed ^ word;

    for (genvar b = 0; b < CRC_W; b++) begin : g_bit
        assign chain[b+1] = chain[b][0] ? ((chain[b] >> 1) ^ POLY_REFL)
                                        : (chain[b] >> 1);
    end

    assign nxt = chain[CRC_W];
endmodule

// File: rtl/fcc_sig_hold.sv
module fcc_sig_hold
    import frame_crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [CRC_W-1:0] cap_val,
    output logic [CRC_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (cap_en) q <= cap_val;
    end

    // R7: the stored signature moves only on a capture
    p_store_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(q));
endmodule

// File: rtl/fcc_ctrl.sv
module fcc_ctrl
    import frame_crc_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] frame_count,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             in_valid,
    input  logic [CRC_W-1:0] in_data,
    input  logic [CRC_W-1:0] frame_nxt,
    input  logic [CRC_W-1:0] stream_nxt,
    output logic [CRC_W-1:0] frame_seed,
    output logic [CRC_W-1:0] stream_seed,
    output logic             in_ready,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [CNT_W-1:0] fail_idx,
    output logic             cap_en,
    output logic [CRC_W-1:0] cap_val
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    fcc_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt_q, frame_idx;
    logic [LEN_W-1:0] len_q, word_idx;
    logic [CRC_W-1:0] frame_acc, stream_acc;
    logic             take, start_ok, last_word, last_frame, match, empty_run;

    assign take       = in_valid && in_ready;
    assign start_ok   = start && ((state == ST_IDLE) || (state == ST_FAIL));
    assign empty_run  = start_ok && (frame_count == '0);
    assign last_word  = (word_idx == len_q - LEN_ONE);
    assign last_frame = (frame_idx == cnt_q - CNT_ONE);
    assign match      = (in_data == ~frame_acc);

    assign frame_seed  = (word_idx == '0) ? CRC_INIT : frame_acc;
    assign stream_seed = stream_acc;

    assign cap_en  = empty_run || ((state == ST_CRC) && take && match && last_frame);
    assign cap_val = empty_run ? '0 : ~stream_acc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_FAIL: begin
                if (start_ok) state_nx = empty_run ? ST_IDLE : ST_DATA;   // T_EMPTY / T_START
            end
            ST_DATA: begin
                if (take && last_word) state_nx = ST_CRC;                 // T_FRAME_END
            end
            ST_CRC: begin
                if (take) begin
                    if (!match)          state_nx = ST_FAIL;              // T_MISMATCH
                    else if (last_frame) state_nx = ST_IDLE;              // T_PASS
                    else                 state_nx = ST_DATA;              // T_NEXT
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        in_ready = (state == ST_DATA) || (state == ST_CRC);
        busy     = in_ready;
    end

    // counters, accumulators and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            len_q      <= LEN_ONE;
            word_idx   <= '0;
            frame_idx  <= '0;
            frame_acc  <= CRC_INIT;
            stream_acc <= CRC_INIT;
            done       <= 1'b0;
            error      <= 1'b0;
            fail_idx   <= '0;
        end else begin
            done <= cap_en;
            if (start_ok) begin
                cnt_q      <= frame_count;
                len_q      <= (frame_len == '0) ? LEN_ONE : frame_len;
                word_idx   <= '0;
                frame_idx  <= '0;
                stream_acc <= CRC_INIT;
                error      <= 1'b0;
                fail_idx   <= '0;
            end else if (take && (state == ST_DATA)) begin
                frame_acc  <= frame_nxt;
                stream_acc <= stream_nxt;
                word_idx   <= last_word ? '0 : word_idx + LEN_ONE;
            end else if (take && (state == ST_CRC)) begin
                if (match) begin
                    frame_idx <= frame_idx + CNT_ONE;
                end else begin
                    error    <= 1'b1;
                    fail_idx <= frame_idx;
                end
            end
        end
    end

    // R5: done is a single pulse unless a new empty run is started
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);
    // R5: a passing run ends clean
    p_done_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !error && !busy);
    // R6: a failure holds and blocks the stream until start
    p_fail_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        error && !start |=> error && !in_ready && $stable(fail_idx));
    // R4: the word counter stays inside the frame
    p_word_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> word_idx < len_q);
    // R8: start while busy leaves the run parameters alone
    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(cnt_q) && $stable(len_q));
endmodule

// File: rtl/frame_crc_checker.sv
module frame_crc_checker
    import frame_crc_pkg::*;
#(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] frame_count,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             in_valid,
    input  logic [31:0]      in_data,
    output logic             in_ready,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [CNT_W-1:0] fail_idx,
    output logic [31:0]      crc_store
);
    logic [CRC_W-1:0] frame_seed, frame_nxt, stream_seed, stream_nxt, cap_val;
    logic             cap_en;

    crc32_word_step u_frame_step (
        .seed (frame_seed),
        .word (in_data),
        .nxt  (frame_nxt)
    );

    crc32_word_step u_stream_step (
        .seed (stream_seed),
        .word (in_data),
        .nxt  (stream_nxt)
    );

    fcc_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .frame_count (frame_count),
        .frame_len   (frame_len),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .frame_nxt   (frame_nxt),
        .stream_nxt  (stream_nxt),
        .frame_seed  (frame_seed),
        .stream_seed (stream_seed),
        .in_ready    (in_ready),
        .busy        (busy),
        .done        (done),
        .error       (error),
        .fail_idx    (fail_idx),
        .cap_en      (cap_en),
        .cap_val     (cap_val)
    );

    fcc_sig_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .cap_val (cap_val),
        .q       (crc_store)
    );
endmodule

// File: tb/frame_crc_checker_bench.sv
module frame_crc_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  frame_count = '0;
    logic [9:0]  frame_len = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, busy, done, error;
    logic [7:0]  fail_idx;
    logic [31:0] crc_store;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_store = '0;

    always #4 clk = ~clk;

    frame_crc_checker u_frame_crc_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_count(frame_count),
        .frame_len(frame_len), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .busy(busy), .done(done), .error(error),
        .fail_idx(fail_idx), .crc_store(crc_store)
    );

    function automatic logic [31:0] b_crc(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r = c;
        for (int i = 0; i < 32; i++) begin
            logic fb = r[0] ^ d[i];
            r = {1'b0, r[31:1]};
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    function automatic logic [31:0] pat(input int f, input int w, input int salt);
        return 32'hA5C30000 ^ (32'(f) << 20) ^ (32'(w) * 32'h9E3779B1) ^ 32'(salt);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start(input int cnt, input int len);
        @(negedge clk);
        start = 1'b1; frame_count = 8'(cnt); frame_len = 10'(len);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w, input int gap);
        for (int g = 0; g < gap; g++) @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // sends a load; bad_frame < 0 means all check words correct
    task automatic run_load(input string req, input int cnt, input int len,
                            input int bad_frame, input int gap, input int salt);
        logic [31:0] sig = 32'hFFFFFFFF;
        int elen = (len == 0) ? 1 : len;
        do_start(cnt, len);
        chk({req, " busy after start"}, 32'(busy), 32'd1);
        for (int f = 0; f < cnt; f++) begin
            logic [31:0] fc = 32'hFFFFFFFF;
            for (int w = 0; w < elen; w++) begin
                logic [31:0] d = pat(f, w, salt);
                fc  = b_crc(fc, d);
                sig = b_crc(sig, d);
                send_word(d, (w % 3 == 1) ? gap : 0);
                chk({req, " no early done"}, 32'(done), 32'd0);
            end
            if (f == bad_frame) begin
                send_word(~fc ^ 32'h0000_0100, gap);
                chk({req, " R6 error"}, 32'(error), 32'd1);
                chk({req, " R6 fail_idx"}, 32'(fail_idx), 32'(f));
                chk({req, " R6 ready low"}, 32'(in_ready), 32'd0);
                chk({req, " R6 busy low"}, 32'(busy), 32'd0);
                chk({req, " R6 no done"}, 32'(done), 32'd0);
                chk({req, " R7 store kept"}, crc_store, exp_store);
                return;
            end
            send_word(~fc, 0);
        end
        exp_store = ~sig;
        chk({req, " R5 done pulse"}, 32'(done), 32'd1);
        chk({req, " R5 error low"}, 32'(error), 32'd0);
        chk({req, " R5 busy low"}, 32'(busy), 32'd0);
        chk({req, " R7 signature"}, crc_store, exp_store);
        @(negedge clk);
        chk({req, " R5 done one cycle"}, 32'(done), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 error", 32'(error), 32'd0);
        chk("R1 ready", 32'(in_ready), 32'd0);
        chk("R1 fail_idx", 32'(fail_idx), 32'd0);
        chk("R1 crc_store", crc_store, 32'd0);
    endtask

    task automatic t_known;
        do_start(1, 1);
        chk("R2 ready after start", 32'(in_ready), 32'd1);
        send_word(32'h34333231, 0);
        send_word(32'h9BE3E0A3, 0);
        chk("R3 known value passes", 32'(done), 32'd1);
        chk("R3 known signature", crc_store, 32'h9BE3E0A3);
        chk("R3 known no error", 32'(error), 32'd0);
        exp_store = 32'h9BE3E0A3;
    endtask

    task automatic t_fail_block;
        run_load("R6 mid", 4, 3, 2, 1, 7);
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'h1234_5678;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        chk("R6 still error", 32'(error), 32'd1);
        chk("R6 idx held", 32'(fail_idx), 32'd2);
        chk("R6 still refused", 32'(in_ready), 32'd0);
        run_load("R2 restart after fail", 2, 2, -1, 0, 9);
        chk("R2 error cleared", 32'(error), 32'd0);
    endtask

    task automatic t_busy_start;
        logic [31:0] fc0 = 32'hFFFFFFFF, fc1 = 32'hFFFFFFFF, sig = 32'hFFFFFFFF;
        do_start(2, 1);
        fc0 = b_crc(fc0, 32'hDEADBEEF); sig = b_crc(sig, 32'hDEADBEEF);
        send_word(32'hDEADBEEF, 0);
        do_start(5, 4);   // R8: ignored
        chk("R8 still busy", 32'(busy), 32'd1);
        send_word(~fc0, 0);
        fc1 = b_crc(fc1, 32'h0BADF00D); sig = b_crc(sig, 32'h0BADF00D);
        send_word(32'h0BADF00D, 0);
        send_word(~fc1, 0);
        exp_store = ~sig;
        chk("R8 done at original count", 32'(done), 32'd1);
        chk("R8 signature", crc_store, exp_store);
    endtask

    task automatic t_empty;
        do_start(0, 3);
        chk("R9 done", 32'(done), 32'd1);
        chk("R9 busy low", 32'(busy), 32'd0);
        chk("R9 store zero", crc_store, 32'd0);
        exp_store = 32'd0;
        @(negedge clk);
        chk("R9 pulse ends", 32'(done), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known();
        run_load("R4 gaps", 3, 5, -1, 2, 1);
        run_load("R3 per-frame restart", 4, 2, -1, 0, 3);
        t_fail_block();
        run_load("R6 last frame", 3, 2, 2, 0, 5);
        t_busy_start();
        t_empty();
        run_load("R10 zero length", 3, 0, -1, 1, 11);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule